// File: doc/BRIEF.md
# Six-Channel Framed Serial Transmitter

This block is the transmit half of a master serial port that ships one set of six 16-bit conversion results per sample period. A single frame-start strobe freezes all six words into a private copy. The block then emits a one-period frame marker, and after it a gated serial clock with a data line that carries the 96 payload bits. The serial clock is made by dividing the system clock, and the rate select picks one of two dividers.

Between frames, the serial clock and the marker rest low. Each of the three outgoing lines has its own output-enable, driven from the enable input, so that pads outside this block can float the lines. A strobe that arrives while a frame is still going out is dropped, and a sticky flag records the loss.

Top module: `sixch_frame_tx`

## Requirements
- R1: `sclk_oe`, `sdo_oe` and `fso_oe` are all high while `ser_en` is high and all low while it is low, so the three lines float whenever the port is disabled.
- R2: `fso` is low between frames. After an accepted strobe it is high for exactly one serial-clock period (2*H system cycles), and `sclk` stays low for that whole time.
- R3: Once `fso` falls, `sclk` completes exactly 96 periods. After that it stays low until the next accepted strobe.
- R4: `samples[16k+15:16k]` is word k, with k = 0..5 standing for V1, I1, V2, I2, V3, I3. Words go out in ascending k and each word goes MSB first, so bit 15 of V1 is the first bit and bit 0 of I3 is the last.
- R5: `sdo` changes only in the cycle where `sclk` falls, or when the payload begins. It is stable for every cycle in which `sclk` is high.
- R6: The serial-clock period is 8 system cycles when `rate_fast` is 0 and 4 when it is 1, with high and low halves of H = 4 or H = 2 cycles. The rate is taken when the strobe is accepted and holds for the whole frame.
- R7: The first rising edge of `sclk` comes H system cycles after `fso` falls.
- R8: All six words are captured in the cycle the strobe is accepted. Changing `samples` or `rate_fast` later in the frame has no effect on that frame.
- R9: A strobe seen while a frame is in progress starts no new frame. It sets `overrun`, which then stays high until reset.
- R10: After synchronous active-high reset, `sclk`, `fso`, `sdo` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial clock is divided from it |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle strobe that begins a frame |
| rate_fast | input | 1 | 0: divide by 8, 1: divide by 4 |
| ser_en | input | 1 | Port enable; when low, the three lines float |
| samples | input | 96 | Six 16-bit words; word k in bits 16k+15..16k |
| sclk | output | 1 | Gated serial clock |
| sclk_oe | output | 1 | Output-enable for sclk |
| sdo | output | 1 | Serial data, MSB first |
| sdo_oe | output | 1 | Output-enable for sdo |
| fso | output | 1 | Frame marker, one serial period wide |
| fso_oe | output | 1 | Output-enable for fso |
| overrun | output | 1 | Sticky flag for a strobe lost mid-frame |

## Verification
The hardest case to reach from the ports is a disturbance that lands in the middle of a running frame. It can be a strobe that must be dropped, or new sample words and a changed rate select that must not leak into the bits already committed. The stimulus reaches this by firing the disturbance at a chosen cycle inside the payload, while the bench checks every cycle of the frame against a waveform it computes from the words captured at frame start. Random frames at both rates, and directed patterns with the sign bit and LSB set, cover word order and bit order.

// File: rtl/sft_pkg.sv
package sft_pkg;
    localparam int CH_NUM     = 6;
    localparam int WORD_W     = 16;
    localparam int FRAME_BITS = CH_NUM * WORD_W;
    localparam int HALF_CNT   = 2 * FRAME_BITS;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SYNC = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        logic load;
        logic shift;
        logic active;
    } shf_ctl_t;

    function automatic int unsigned half_len(input logic fast,
                                             input int unsigned div_slow,
                                             input int unsigned div_fast);
        return fast ? (div_fast / 2) : (div_slow / 2);
    endfunction
endpackage

// File: rtl/sft_sequencer.sv
module sft_sequencer
    import sft_pkg::*;
#(
    parameter int DIV_SLOW = 8,
    parameter int DIV_FAST = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     frame_start,
    input  logic     rate_fast,
    output logic     sclk_lvl,
    output logic     fso_lvl,
    output shf_ctl_t ctl,
    output logic     overrun
);
    localparam int TICK_W = $clog2(DIV_SLOW);
    localparam int HALF_W = $clog2(HALF_CNT);
    localparam logic [TICK_W-1:0] HMAX_SLOW = TICK_W'(half_len(1'b0, DIV_SLOW, DIV_FAST) - 1);
    localparam logic [TICK_W-1:0] HMAX_FAST = TICK_W'(half_len(1'b1, DIV_SLOW, DIV_FAST) - 1);
    localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(HALF_CNT - 1);

    phase_e            phase_q;
    logic [TICK_W-1:0] tick_q;
    logic [TICK_W-1:0] hmax_q;
    logic [HALF_W-1:0] half_q;
    logic              overrun_q;
    logic              half_end;

    assign half_end = (tick_q == hmax_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            tick_q    <= '0;
            hmax_q    <= '0;
            half_q    <= '0;
            overrun_q <= 1'b0;
        end else begin
            if (frame_start && phase_q != PH_IDLE) begin
                overrun_q <= 1'b1;
            end
            case (phase_q)
                PH_IDLE: begin
                    if (frame_start) begin
                        phase_q <= PH_SYNC;
                        tick_q  <= '0;
                        half_q  <= '0;
                        hmax_q  <= rate_fast ? HMAX_FAST : HMAX_SLOW;
                    end
                end
                PH_SYNC: begin
                    if (half_end) begin
                        tick_q <= '0;
                        if (half_q[0]) begin
                            phase_q <= PH_DATA;
                            half_q  <= '0;
                        end else begin
                            half_q <= half_q + 1'b1;
                        end
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                PH_DATA: begin
                    if (half_end) begin
                        tick_q <= '0;
                        if (half_q == HALF_LAST) begin
                            phase_q <= PH_IDLE;
                            half_q  <= '0;
                        end else begin
                            half_q <= half_q + 1'b1;
                        end
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl.load   = (phase_q == PH_IDLE) && frame_start;
        ctl.shift  = (phase_q == PH_DATA) && half_end && half_q[0];
        ctl.active = (phase_q == PH_DATA);
        sclk_lvl   = (phase_q == PH_DATA) && half_q[0];
        fso_lvl    = (phase_q == PH_SYNC);
    end

    assign overrun = overrun_q;

    // R3: the half-period index never passes the end of the payload
    assert_half_bound_R3: assert property (@(posedge clk) disable iff (rst)
        half_q <= HALF_LAST);

    // R6: the latched rate holds while a frame runs
    assert_rate_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE) |=> $stable(hmax_q));

    // R9: a mid-frame strobe raises the flag
    assert_overrun_set_R9: assert property (@(posedge clk) disable iff (rst)
        (frame_start && phase_q != PH_IDLE) |=> overrun_q);

    // R9: the flag is sticky
    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        overrun_q |=> overrun_q);

    // R9: a mid-frame strobe does not restart the frame
    assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (frame_start && phase_q == PH_DATA && !half_end) |=> (phase_q == PH_DATA));
endmodule

// File: rtl/sft_shadow.sv
module sft_shadow
    import sft_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [FRAME_BITS-1:0] samples,
    input  shf_ctl_t              ctl,
    output logic                  sdo_lvl
);
    logic [FRAME_BITS-1:0] load_vec;
    logic [FRAME_BITS-1:0] sr_q;

    // word k goes out k-th, so it sits k words below the top of the register
    for (genvar k = 0; k < CH_NUM; k++) begin : g_order
        assign load_vec[FRAME_BITS-1-k*WORD_W -: WORD_W] = samples[k*WORD_W +: WORD_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (ctl.load) begin
            sr_q <= load_vec;
        end else if (ctl.shift) begin
            sr_q <= {sr_q[FRAME_BITS-2:0], 1'b0};
        end
    end

    assign sdo_lvl = ctl.active ? sr_q[FRAME_BITS-1] : 1'b0;

    // R8: the shadow copy moves only on capture or on a serial falling edge
    assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!ctl.load && !ctl.shift) |=> $stable(sr_q));
endmodule

// File: rtl/sft_pads.sv
module sft_pads (
    input  logic clk,
    input  logic rst,
    input  logic ser_en,
    input  logic sclk_lvl,
    input  logic fso_lvl,
    input  logic sdo_lvl,
    output logic sclk,
    output logic sclk_oe,
    output logic sdo,
    output logic sdo_oe,
    output logic fso,
    output logic fso_oe
);
    assign sclk    = sclk_lvl;
    assign sdo     = sdo_lvl;
    assign fso     = fso_lvl;
    assign sclk_oe = ser_en;
    assign sdo_oe  = ser_en;
    assign fso_oe  = ser_en;

    // R2: the serial clock rests during the frame marker
    assert_quiet_marker_R2: assert property (@(posedge clk) disable iff (rst)
        fso_lvl |-> !sclk_lvl);

    // R5: data holds across every high serial-clock cycle
    assert_sdo_steady_R5: assert property (@(posedge clk) disable iff (rst)
        (sclk_lvl && $past(sclk_lvl)) |-> $stable(sdo_lvl));
endmodule

// File: rtl/sixch_frame_tx.sv
module sixch_frame_tx
    import sft_pkg::*;
#(
    parameter int DIV_SLOW = 8,
    parameter int DIV_FAST = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  frame_start,
    input  logic                  rate_fast,
    input  logic                  ser_en,
    input  logic [FRAME_BITS-1:0] samples,
    output logic                  sclk,
    output logic                  sclk_oe,
    output logic                  sdo,
    output logic                  sdo_oe,
    output logic                  fso,
    output logic                  fso_oe,
    output logic                  overrun
);
    shf_ctl_t ctl;
    logic     sclk_lvl;
    logic     fso_lvl;
    logic     sdo_lvl;

    sft_sequencer #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_seq (
        .clk(clk), .rst(rst), .frame_start(frame_start), .rate_fast(rate_fast),
        .sclk_lvl(sclk_lvl), .fso_lvl(fso_lvl), .ctl(ctl), .overrun(overrun)
    );

    sft_shadow u_shadow (
        .clk(clk), .rst(rst), .samples(samples), .ctl(ctl), .sdo_lvl(sdo_lvl)
    );

    sft_pads u_pads (
        .clk(clk), .rst(rst), .ser_en(ser_en),
        .sclk_lvl(sclk_lvl), .fso_lvl(fso_lvl), .sdo_lvl(sdo_lvl),
        .sclk(sclk), .sclk_oe(sclk_oe), .sdo(sdo), .sdo_oe(sdo_oe),
        .fso(fso), .fso_oe(fso_oe)
    );
endmodule

// File: tb/sixch_frame_tx_tb.sv
module sixch_frame_tx_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        frame_start;
    logic        rate_fast;
    logic        ser_en;
    logic [95:0] samples;
    logic        sclk, sclk_oe, sdo, sdo_oe, fso, fso_oe, overrun;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    sixch_frame_tx u_dut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .rate_fast(rate_fast),
        .ser_en(ser_en), .samples(samples),
        .sclk(sclk), .sclk_oe(sclk_oe), .sdo(sdo), .sdo_oe(sdo_oe),
        .fso(fso), .fso_oe(fso_oe), .overrun(overrun)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: run hung, got %0d cycles, expected fewer than 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // bit b of the frame: word b/16 (V1,I1,V2,I2,V3,I3), MSB first
    function automatic logic frame_bit(input logic [95:0] s, input int b);
        int ch  = b / 16;
        int pos = 15 - (b % 16);
        return s[ch*16 + pos];
    endfunction

    // disturb: 0 none, 1 new samples and rate mid-frame, 2 strobe mid-frame
    task automatic run_frame(input logic fast, input logic [95:0] words, input int disturb);
        int   h = fast ? 2 : 4;
        int   last = 2*h + 192*h;
        int   rises = 0;
        int   first_rise = -1;
        int   bad_fso = 0, bad_sclk = 0, bad_sdo = 0, bad_hold = 0;
        logic prev_sclk = 1'b0, prev_sdo = 1'b0;
        logic [95:0] cap = words;
        @(negedge clk);
        samples     = words;
        rate_fast   = fast;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int n = 1; n <= last + 12; n++) begin
            logic ef, es, ed;
            if (n > 1) @(negedge clk);
            ef = 1'b0; es = 1'b0; ed = 1'b0;
            if (n <= 2*h) begin
                ef = 1'b1;
            end else if (n <= last) begin
                int t = n - 2*h - 1;
                int hf = t / h;
                es = hf[0];
                ed = frame_bit(cap, hf / 2);
            end
            if (fso !== ef) bad_fso++;
            if (sclk !== es) bad_sclk++;
            if (sdo !== ed) bad_sdo++;
            if (prev_sclk && sclk && (sdo !== prev_sdo)) bad_hold++;
            if (sclk && !prev_sclk) begin
                rises++;
                if (first_rise < 0) first_rise = n;
            end
            prev_sclk = sclk;
            prev_sdo  = sdo;
            if (n == 60 && disturb == 1) begin
                samples   = ~words;
                rate_fast = ~fast;
            end
            if (n == 60 && disturb == 2) frame_start = 1'b1;
            if (n == 61) frame_start = 1'b0;
            if (n == 62 && disturb == 2) chk("R9 overrun after mid-frame strobe", int'(overrun), 1);
        end
        chk("R2 marker width and idle level", bad_fso, 0);
        chk("R6 serial clock period for rate", bad_sclk, 0);
        if (disturb == 1) chk("R8 frame unchanged by late samples", bad_sdo, 0);
        else chk("R4 channel order and bit order", bad_sdo, 0);
        chk("R5 sdo steady while sclk high", bad_hold, 0);
        chk("R3 rising edges per frame", rises, 96);
        chk("R7 first rise after marker", first_rise, 2*h + h + 1);
        if (disturb == 2) chk("R9 no second frame from dropped strobe", rises, 96);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; frame_start = 1'b0; rate_fast = 1'b0; ser_en = 1'b1; samples = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset sclk", int'(sclk), 0);
        chk("R10 reset fso", int'(fso), 0);
        chk("R10 reset sdo", int'(sdo), 0);
        chk("R10 reset overrun", int'(overrun), 0);

        ser_en = 1'b0;
        @(negedge clk);
        chk("R1 oe low when disabled", int'({sclk_oe, sdo_oe, fso_oe}), 0);
        ser_en = 1'b1;
        @(negedge clk);
        chk("R1 oe high when enabled", int'({sclk_oe, sdo_oe, fso_oe}), 7);

        run_frame(1'b0, {16'h0001, 16'hFFFF, 16'h0000, 16'h7FFF, 16'h8000, 16'hA5C3}, 0);
        run_frame(1'b1, {16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 16'h0F0F, 16'h8001}, 0);
        for (int i = 0; i < 6; i++) begin
            logic [95:0] w = {$urandom, $urandom, $urandom};
            run_frame(1'($urandom & 1), w, 0);
        end
        run_frame(1'b0, {$urandom, $urandom, $urandom}, 1);
        run_frame(1'b1, {$urandom, $urandom, $urandom}, 1);
        chk("R9 overrun still clear", int'(overrun), 0);
        run_frame(1'b1, {$urandom, $urandom, $urandom}, 2);
        repeat (20) @(negedge clk);
        chk("R9 overrun sticky", int'(overrun), 1);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 overrun cleared by reset", int'(overrun), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule